// File: doc/BRIEF.md
# Multi-Cycle RISC Processor Core

This block is a compact 32-bit load/store processor. It executes a small subset of a classic three-format RISC instruction set. Every instruction passes through a short series of steps, one step per clock, under a control state machine. The steps are fetch, decode with register read, execute or address calculation, memory access or branch completion, and register write-back. Each step loads explicit internal latches: the instruction register, next-PC, two operand registers, the extended immediate, the ALU result, and the loaded data word. As a result, an instruction class with less work to do finishes in fewer clocks than a load.

The core has two separate memory ports, one for instructions and one for data. Both have a read that completes within the same cycle and a write that commits on the clock edge. The core drives the address and the strobes. The memory returns read data combinationally during the step that asks for it.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC is set to `RESET_PC` (default 0) and the state machine enters the fetch step. During reset, `imem_re` is 1, `imem_addr` equals `RESET_PC` and `dmem_we` is 0.
- R2: In the fetch step, `imem_re` is 1 and `imem_addr` is the PC. The word read is latched as the instruction, and the PC advances by 4. Instructions are fetched at consecutive word addresses unless a branch or jump redirects the flow.
- R3: An instruction with opcode bits [31:26] = 0x00 is register-register. Its bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Sources are bits [25:21] and [20:16]. The result goes to the register named by bits [15:11].
- R4: Opcode 0x08 adds the sign-extended 16-bit immediate (bits [15:0]) to the register named by bits [25:21], and writes the sum to the register named by bits [20:16]. Opcode 0x0F writes the immediate into bits [31:16] of that register and clears bits [15:0].
- R5: Opcode 0x23 reads data memory at the base register plus the sign-extended immediate, and writes the word to the register named by bits [20:16]. Negative offsets are supported.
- R6: Opcode 0x2B writes the value of the register named by bits [20:16] to data memory at the base register plus the sign-extended immediate. It raises `dmem_we` for exactly one cycle, and `dmem_re` and `dmem_we` are never high together.
- R7: Opcode 0x04 branches when its two source registers are equal, and opcode 0x05 branches when they differ. A taken branch continues at PC+4 plus four times the sign-extended immediate. An untaken branch continues at PC+4.
- R8: Opcode 0x02 continues at the address formed from bits [31:28] of PC+4, the 26-bit field in bits [25:0], and two zero bits.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: A load occupies 5 cycles from its fetch to the next fetch. A jump occupies 3 cycles. Register-register, add-immediate, upper-immediate, store and both branch instructions occupy 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction memory byte address (the PC) |
| imem_re | output | 1 | Instruction read strobe, high in the fetch step |
| imem_rdata | input | 32 | Instruction word returned in the same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_re | output | 1 | Data read strobe for loads |
| dmem_we | output | 1 | Data write strobe for stores |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data returned in the same cycle |

## Verification
A directed program runs first. Its hand-computed results separate signed from unsigned comparison, show that writes to register 0 are dropped, and contrast taken with untaken branches. It also checks that jumps and branches skip the right instructions and that a negative load offset is handled. Several seeded random programs follow. They mix all supported operations on arbitrary registers, including register 0, and use forward branches and jumps. These programs expose wrong operand routing, wrong destination fields and wrong data forwarding between steps. Every fetch address is compared with an instruction-level model, every store's address and data is compared, and every cycle count per instruction is compared. A register dump at the end of each program makes the whole register file visible through the data port.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WBACK  = 3'd4
   } step_e;

   typedef enum logic [2:0] {
      CL_REG    = 3'd0,
      CL_ADDI   = 3'd1,
      CL_LUI    = 3'd2,
      CL_LOAD   = 3'd3,
      CL_STORE  = 3'd4,
      CL_BRANCH = 3'd5,
      CL_JUMP   = 3'd6,
      CL_NONE   = 3'd7
   } iclass_e;

   typedef enum logic [2:0] {
      AL_ADD = 3'd0,
      AL_SUB = 3'd1,
      AL_AND = 3'd2,
      AL_OR  = 3'd3,
      AL_SLT = 3'd4
   } alu_op_e;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_JMP  = 6'h02;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_BNE  = 6'h05;
   localparam logic [5:0] OPC_ADDI = 6'h08;
   localparam logic [5:0] OPC_LUI  = 6'h0F;
   localparam logic [5:0] OPC_LD   = 6'h23;
   localparam logic [5:0] OPC_ST   = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   function automatic iclass_e classify(input logic [5:0] opc);
      case (opc)
         OPC_REG:  return CL_REG;
         OPC_ADDI: return CL_ADDI;
         OPC_LUI:  return CL_LUI;
         OPC_LD:   return CL_LOAD;
         OPC_ST:   return CL_STORE;
         OPC_BEQ,
         OPC_BNE:  return CL_BRANCH;
         OPC_JMP:  return CL_JUMP;
         default:  return CL_NONE;
      endcase
   endfunction

   function automatic alu_op_e funct_to_op(input logic [5:0] fn);
      case (fn)
         FN_SUB:  return AL_SUB;
         FN_AND:  return AL_AND;
         FN_OR:   return AL_OR;
         FN_SLT:  return AL_SLT;
         default: return AL_ADD;
      endcase
   endfunction

endpackage

// File: rtl/mc_core_regs.sv
module mc_core_regs #(
   parameter int XLEN           = 32,
   parameter int REG_CNT        = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int RIDX_W        = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RIDX_W-1:0] rd_a_idx,
   input  logic [RIDX_W-1:0] rd_b_idx,
   output logic [XLEN-1:0]   rd_a_val,
   output logic [XLEN-1:0]   rd_b_val,
   input  logic              wr_en,
   input  logic [RIDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]   wr_val
);

   logic [XLEN-1:0] cells [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign cells[i] = '0;
      end else begin : g_live
         logic [XLEN-1:0] cell_q;
         if (CLEAR_ON_RESET) begin : g_clr
            always_ff @(posedge clk) begin
               if (rst)
                  cell_q <= '0;
               else if (wr_en && (wr_idx == RIDX_W'(i)))
                  cell_q <= wr_val;
            end
         end else begin : g_keep
            always_ff @(posedge clk) begin
               if (wr_en && (wr_idx == RIDX_W'(i)))
                  cell_q <= wr_val;
            end
         end
         assign cells[i] = cell_q;
      end
   end

   assign rd_a_val = cells[rd_a_idx];
   assign rd_b_val = cells[rd_b_idx];

endmodule

// File: rtl/mc_core_alu.sv
module mc_core_alu
   import mc_core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] result
);

   always_comb begin
      case (op)
         AL_SUB:  result = opnd_a - opnd_b;
         AL_AND:  result = opnd_a & opnd_b;
         AL_OR:   result = opnd_a | opnd_b;
         AL_SLT:  result = ($signed(opnd_a) < $signed(opnd_b)) ? XLEN'(1) : '0;
         default: result = opnd_a + opnd_b;
      endcase
   end

endmodule

// File: rtl/mc_core_seq.sv
module mc_core_seq
   import mc_core_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  iclass_e cls,
   output step_e   step
);

   step_e step_d;

   always_comb begin
      step_d = ST_FETCH;
      case (step)
         ST_FETCH:  step_d = ST_DECODE;
         ST_DECODE: step_d = ST_EXEC;
         ST_EXEC: begin
            case (cls)
               CL_REG, CL_ADDI, CL_LUI:      step_d = ST_WBACK;
               CL_LOAD, CL_STORE, CL_BRANCH: step_d = ST_MEM;
               default:                      step_d = ST_FETCH;
            endcase
         end
         ST_MEM:    step_d = (cls == CL_LOAD) ? ST_WBACK : ST_FETCH;
         default:   step_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) step <= ST_FETCH;
      else     step <= step_d;
   end

   p_wback_ends_r10: assert property (@(posedge clk) disable iff (rst)
      (step == ST_WBACK) |=> (step == ST_FETCH));

   p_jump_short_r10: assert property (@(posedge clk) disable iff (rst)
      (step == ST_EXEC && cls == CL_JUMP) |=> (step == ST_FETCH));

   p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
      (step == ST_FETCH) |=> (step == ST_DECODE));

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_core_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          REG_CNT  = 32,
   parameter logic [31:0] RESET_PC = 32'h0000_0000,
   parameter bit          RF_CLEAR = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] imem_addr,
   output logic        imem_re,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic        dmem_re,
   output logic        dmem_we,
   output logic [31:0] dmem_wdata,
   input  logic [31:0] dmem_rdata
);

   localparam int RIDX_W  = $clog2(REG_CNT);
   localparam int IMM_W   = 16;
   localparam int JFLD_W  = 26;
   localparam int PCHI_W  = XLEN - JFLD_W - 2;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_core: XLEN must be 32 for this instruction encoding");
   end
   if (REG_CNT != 32) begin : g_bad_regs
      $error("mc_core: REG_CNT must be 32 to match 5-bit register fields");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("mc_core: RESET_PC must be word aligned");
   end

   step_e           step;
   iclass_e         cls;
   alu_op_e         aop;

   logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
   logic            cond_q;

   logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
   logic [5:0]        f_op, f_fn;
   logic [IMM_W-1:0]  f_imm;
   logic [JFLD_W-1:0] f_jt;
   logic              unused_shamt;

   logic [XLEN-1:0] rf_a, rf_b, rf_wd;
   logic [RIDX_W-1:0] rf_wa;
   logic            rf_we;
   logic [XLEN-1:0] src_a, src_b, alu_y;

   assign f_op  = ir_q[31:26];
   assign f_rs  = ir_q[25:21];
   assign f_rt  = ir_q[20:16];
   assign f_rd  = ir_q[15:11];
   assign f_fn  = ir_q[5:0];
   assign f_imm = ir_q[15:0];
   assign f_jt  = ir_q[25:0];
   assign unused_shamt = ^ir_q[10:6];

   assign cls = classify(f_op);
   assign aop = (cls == CL_REG) ? funct_to_op(f_fn) : AL_ADD;

   mc_core_seq u_seq (
      .clk  (clk),
      .rst  (rst),
      .cls  (cls),
      .step (step)
   );

   mc_core_regs #(
      .XLEN           (XLEN),
      .REG_CNT        (REG_CNT),
      .CLEAR_ON_RESET (RF_CLEAR)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .rd_a_idx (f_rs),
      .rd_b_idx (f_rt),
      .rd_a_val (rf_a),
      .rd_b_val (rf_b),
      .wr_en    (rf_we),
      .wr_idx   (rf_wa),
      .wr_val   (rf_wd)
   );

   always_comb begin
      src_a = a_q;
      src_b = imm_q;
      case (cls)
         CL_REG:    src_b = b_q;
         CL_BRANCH: begin
            src_a = npc_q;
            src_b = {imm_q[XLEN-3:0], 2'b00};
         end
         default: ;
      endcase
   end

   mc_core_alu #(.XLEN(XLEN)) u_alu (
      .opnd_a (src_a),
      .opnd_b (src_b),
      .op     (aop),
      .result (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= RESET_PC;
         npc_q  <= '0;
         ir_q   <= '0;
         a_q    <= '0;
         b_q    <= '0;
         imm_q  <= '0;
         alu_q  <= '0;
         lmd_q  <= '0;
         cond_q <= 1'b0;
      end else begin
         case (step)
            ST_FETCH: begin
               ir_q  <= imem_rdata;
               pc_q  <= pc_q + XLEN'(4);
               npc_q <= pc_q + XLEN'(4);
            end
            ST_DECODE: begin
               a_q   <= rf_a;
               b_q   <= rf_b;
               imm_q <= {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
            end
            ST_EXEC: begin
               if (cls == CL_LUI) alu_q <= {f_imm, {(XLEN-IMM_W){1'b0}}};
               else               alu_q <= alu_y;
               cond_q <= (a_q == b_q) ^ (f_op == OPC_BNE);
               if (cls == CL_JUMP)
                  pc_q <= {npc_q[XLEN-1 -: PCHI_W], f_jt, 2'b00};
            end
            ST_MEM: begin
               if (cls == CL_LOAD) lmd_q <= dmem_rdata;
               if (cls == CL_BRANCH && cond_q) pc_q <= alu_q;
            end
            default: ;
         endcase
      end
   end

   assign rf_we = (step == ST_WBACK);
   assign rf_wa = (cls == CL_REG) ? f_rd : f_rt;
   assign rf_wd = (cls == CL_LOAD) ? lmd_q : alu_q;

   assign imem_addr  = pc_q;
   assign imem_re    = (step == ST_FETCH);
   assign dmem_addr  = alu_q;
   assign dmem_wdata = b_q;
   assign dmem_we    = (step == ST_MEM) && (cls == CL_STORE);
   assign dmem_re    = (step == ST_MEM) && (cls == CL_LOAD);

   p_fetch_latch_r2: assert property (@(posedge clk) disable iff (rst)
      (step == ST_FETCH) |=> (npc_q == $past(pc_q) + 32'd4) && (ir_q == $past(imem_rdata)));

   p_r0_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (step == ST_DECODE && f_rs == '0) |=> (a_q == '0));

   p_mem_excl_r6: assert property (@(posedge clk) disable iff (rst)
      !(dmem_we && dmem_re));

   p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (step == ST_DECODE || step == ST_WBACK) |=> $stable(pc_q));

   p_untaken_r7: assert property (@(posedge clk) disable iff (rst)
      (step == ST_MEM && cls == CL_BRANCH && !cond_q) |=> (pc_q == $past(npc_q)));

   p_jump_region_r8: assert property (@(posedge clk) disable iff (rst)
      (step == ST_EXEC && cls == CL_JUMP) |=>
         (pc_q[1:0] == 2'b00) && (pc_q[31:28] == $past(npc_q[31:28])));

endmodule

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;

   localparam int PM_WORDS = 128;
   localparam int DM_WORDS = 64;
   localparam int RND_N    = 70;
   localparam int DUMP_AT  = 70;
   localparam int HALT_AT  = DUMP_AT + 32;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        imem_re, dmem_re, dmem_we;

   logic [31:0] pm      [PM_WORDS];
   logic [31:0] dm_dut  [DM_WORDS];
   logic [31:0] dm_ref  [DM_WORDS];
   logic [31:0] dm_init [DM_WORDS];
   logic [31:0] rf_ref  [32];

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] iss_pc;
   int          exp_gap;
   int          prev_kind;
   bit          exp_st_v;
   logic [31:0] exp_st_a, exp_st_d;
   bit          st_seen;

   always #5 clk = ~clk;

   mc_core dut_i (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_re    (imem_re),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_re    (dmem_re),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = pm[imem_addr[8:2]];
   assign dmem_rdata = dm_dut[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dm_dut[dmem_addr[7:2]] <= dmem_wdata;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [4:0] rd);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(input int idx);
      return {6'h02, 26'(idx)};
   endfunction

   // instruction-level model, one instruction per call
   task automatic iss_step();
      logic [31:0] ins, npc, va, vb, sx, res;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd;
      ins = pm[iss_pc[8:2]];
      npc = iss_pc + 32'd4;
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      va = rf_ref[rs]; vb = rf_ref[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      exp_gap = 4; prev_kind = 0; exp_st_v = 1'b0;
      iss_pc = npc;
      case (op)
         6'h00: begin
            case (fn)
               6'h22: res = va - vb;
               6'h24: res = va & vb;
               6'h25: res = va | vb;
               6'h2A: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
               default: res = va + vb;
            endcase
            rf_ref[rd] = res;
         end
         6'h08: rf_ref[rt] = va + sx;
         6'h0F: rf_ref[rt] = {ins[15:0], 16'h0000};
         6'h23: begin
            rf_ref[rt] = dm_ref[(va + sx) >> 2 & 32'h3F];
            exp_gap = 5;
         end
         6'h2B: begin
            exp_st_v = 1'b1;
            exp_st_a = va + sx;
            exp_st_d = vb;
            dm_ref[(va + sx) >> 2 & 32'h3F] = vb;
         end
         6'h04, 6'h05: begin
            prev_kind = 1;
            if ((va == vb) ^ (op == 6'h05)) iss_pc = npc + {sx[29:0], 2'b00};
         end
         6'h02: begin
            prev_kind = 2;
            exp_gap = 3;
            iss_pc = {npc[31:28], ins[25:0], 2'b00};
         end
         default: exp_gap = 3;
      endcase
      rf_ref[0] = 32'h0;
   endtask

   task automatic add_dump();
      for (int k = 0; k < 32; k++) pm[DUMP_AT + k] = enc_i(6'h2B, 5'd0, 5'(k), 16'(4 * k));
      pm[HALT_AT] = enc_j(HALT_AT);
   endtask

   task automatic clear_prog();
      for (int k = 0; k < PM_WORDS; k++) pm[k] = 32'h0;
   endtask

   task automatic run_prog();
      int  cyc, last;
      bit  done;
      string ptag;
      for (int k = 0; k < DM_WORDS; k++) begin
         dm_dut[k] = dm_init[k];
         dm_ref[k] = dm_init[k];
      end
      for (int k = 0; k < 32; k++) rf_ref[k] = 32'h0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(imem_re == 1'b1, "R1 fetch step during reset", 32'(imem_re), 32'd1);
      check(imem_addr == 32'h0, "R1 PC during reset", imem_addr, 32'h0);
      check(dmem_we == 1'b0, "R1 no write during reset", 32'(dmem_we), 32'd0);
      rst = 1'b0;
      #1;
      check(imem_re && imem_addr == 32'h0, "R1 first fetch at reset PC", imem_addr, 32'h0);
      iss_pc = 32'h0;
      iss_step();
      st_seen = 1'b0;
      cyc = 0; last = 0; done = 1'b0;
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (dmem_we) begin
            st_seen = 1'b1;
            check(exp_st_v, "R6 unexpected store", dmem_addr, 32'h0);
            check(dmem_addr == exp_st_a, "R6 store address", dmem_addr, exp_st_a);
            check(dmem_wdata == exp_st_d, "R6 store data (R3 R4 R5 R9 results)",
                  dmem_wdata, exp_st_d);
         end
         if (imem_re) begin
            check(cyc - last == exp_gap, "R10 cycles per instruction",
                  32'(cyc - last), 32'(exp_gap));
            if (exp_st_v) check(st_seen, "R6 store issued", 32'(st_seen), 32'd1);
            ptag = (prev_kind == 1) ? "R7 branch flow" :
                   (prev_kind == 2) ? "R8 jump target" : "R2 sequential fetch";
            check(imem_addr == iss_pc, ptag, imem_addr, iss_pc);
            if (imem_addr == 32'(HALT_AT * 4) && iss_pc == 32'(HALT_AT * 4)) done = 1'b1;
            else begin
               iss_pc = imem_addr;
               iss_step();
            end
            last = cyc;
            st_seen = 1'b0;
         end
      end
      check(done, "R2 program reached halt", 32'(done), 32'd1);
   endtask

   task automatic build_directed();
      clear_prog();
      pm[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'hFFFB);
      pm[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'd3);
      pm[2]  = enc_r(6'h2A, 5'd1, 5'd2, 5'd3);
      pm[3]  = enc_r(6'h22, 5'd2, 5'd1, 5'd4);
      pm[4]  = enc_i(6'h0F, 5'd0, 5'd5, 16'h1234);
      pm[5]  = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
      pm[6]  = enc_i(6'h2B, 5'd0, 5'd1, 16'd128);
      pm[7]  = enc_i(6'h23, 5'd0, 5'd6, 16'd128);
      pm[8]  = enc_i(6'h04, 5'd2, 5'd2, 16'd1);
      pm[9]  = enc_i(6'h08, 5'd0, 5'd7, 16'd99);
      pm[10] = enc_i(6'h05, 5'd2, 5'd2, 16'd1);
      pm[11] = enc_i(6'h08, 5'd0, 5'd8, 16'd42);
      pm[12] = enc_j(14);
      pm[13] = enc_i(6'h08, 5'd0, 5'd9, 16'd77);
      pm[14] = enc_r(6'h24, 5'd1, 5'd2, 5'd10);
      pm[15] = enc_r(6'h25, 5'd1, 5'd2, 5'd11);
      pm[16] = enc_r(6'h20, 5'd1, 5'd2, 5'd12);
      pm[17] = enc_i(6'h08, 5'd0, 5'd13, 16'd200);
      pm[18] = enc_i(6'h23, 5'd13, 5'd14, 16'hFFB8);
      pm[19] = enc_j(DUMP_AT);
      add_dump();
   endtask

   task automatic build_random();
      clear_prog();
      for (int i = 0; i < RND_N; i++) begin
         int unsigned k   = $urandom_range(0, 10);
         logic [4:0]  rs  = 5'($urandom_range(0, 31));
         logic [4:0]  rt  = 5'($urandom_range(0, 31));
         logic [4:0]  rd  = 5'($urandom_range(0, 31));
         logic [15:0] imm = 16'($urandom);
         int          off = $urandom_range(0, 3);
         if (off > RND_N - i - 1) off = RND_N - i - 1;
         case (k)
            0: pm[i] = enc_r(6'h20, rs, rt, rd);
            1: pm[i] = enc_r(6'h22, rs, rt, rd);
            2: pm[i] = enc_r(6'h24, rs, rt, rd);
            3: pm[i] = enc_r(6'h25, rs, rt, rd);
            4: pm[i] = enc_r(6'h2A, rs, rt, rd);
            5: pm[i] = enc_i(6'h08, rs, rt, imm);
            6: pm[i] = enc_i(6'h0F, rs, rt, imm);
            7: pm[i] = enc_i(6'h23, 5'd0, rt, 16'(128 + 4 * $urandom_range(0, 31)));
            8: pm[i] = enc_i(6'h2B, 5'd0, rt, 16'(128 + 4 * $urandom_range(0, 31)));
            9: pm[i] = enc_i(($urandom_range(0, 1) != 0) ? 6'h05 : 6'h04,
                             5'(rs & 5'd3), 5'(rt & 5'd3), 16'(off));
            default: pm[i] = enc_j(i + 1 + off);
         endcase
      end
      add_dump();
   endtask

   initial begin
      void'($urandom(32'd611));
      for (int k = 0; k < DM_WORDS; k++) dm_init[k] = $urandom;

      build_directed();
      run_prog();
      check(dm_dut[0]  == 32'h0,        "R9 register 0 ignores writes", dm_dut[0], 32'h0);
      check(dm_dut[3]  == 32'h1,        "R3 signed slt",               dm_dut[3], 32'h1);
      check(dm_dut[4]  == 32'h8,        "R3 subtract",                 dm_dut[4], 32'h8);
      check(dm_dut[5]  == 32'h12340000, "R4 upper immediate",          dm_dut[5], 32'h12340000);
      check(dm_dut[1]  == 32'hFFFFFFFB, "R4 addi sign extension",      dm_dut[1], 32'hFFFFFFFB);
      check(dm_dut[6]  == 32'hFFFFFFFB, "R5 load after store",         dm_dut[6], 32'hFFFFFFFB);
      check(dm_dut[7]  == 32'h0,        "R7 taken branch skips",       dm_dut[7], 32'h0);
      check(dm_dut[8]  == 32'd42,       "R7 untaken branch falls through", dm_dut[8], 32'd42);
      check(dm_dut[9]  == 32'h0,        "R8 jump skips",               dm_dut[9], 32'h0);
      check(dm_dut[10] == 32'h3,        "R3 and",                      dm_dut[10], 32'h3);
      check(dm_dut[11] == 32'hFFFFFFFB, "R3 or",                       dm_dut[11], 32'hFFFFFFFB);
      check(dm_dut[12] == 32'hFFFFFFFE, "R3 add",                      dm_dut[12], 32'hFFFFFFFE);
      check(dm_dut[14] == 32'hFFFFFFFB, "R5 negative offset",          dm_dut[14], 32'hFFFFFFFB);

      for (int r = 0; r < 6; r++) begin
         build_random();
         run_prog();
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule